// File: doc/BRIEF.md
# Bank Pin-Event Interrupt Detector

This block watches a bank of general-purpose pins, grouped into ports of eight pins each, and turns pin activity into interrupt requests. Each pin carries a three-bit trigger setting that picks one of five conditions: a rising edge, a falling edge, either edge, a high level or a low level. When a pin's condition is seen, the pin's status bit is set and stays set until software clears it with a one-cycle clear pulse.

A port raises its request when any pin has both its status bit and its enable bit set. The requests of all ports in the bank are ORed into a single bank interrupt line. The pin vector arrives already synchronised to the clock. The trigger settings, enables and clear pulses come from a register file outside this block. The status vector is returned so that software can find which pin fired.

Top module: `gpio_det_bank`

## Requirements
- R1: Pin n of port p is bit 8p+n of the pin, enable, clear and status vectors. Its trigger setting lies in the 24-bit slice of `trig_cfg_i` that starts at bit 24p: bit n is polarity, bit 8+n selects edge sensing, and bit 16+n selects dual-edge sensing.
- R2: With edge=1, dual=0 and polarity=1, a pin that was 0 in one cycle and is 1 in the next sets its status at the following clock edge. No other transition sets it.
- R3: With edge=1, dual=0 and polarity=0, only a 1-to-0 transition sets status.
- R4: With edge=1 and dual=1, a transition in either direction sets status, whatever the polarity bit holds.
- R5: With edge=0, the pin is level sensed. Polarity=1 sets status on every clock edge where the pin is 1, and polarity=0 sets it on every clock edge where the pin is 0. The dual bit has no effect in this mode.
- R6: Status is sticky. It stays at 1 until the pin's clear bit is 1 at a clock edge, and it reads 0 after that edge unless a new detection occurs.
- R7: A detection at the same clock edge as a clear wins, so status stays 1. A level-sensed pin whose level is still active therefore cannot be cleared.
- R8: Status sets whether or not the pin's enable is set. `irq_o` is the OR over all pins of status AND enable, and it follows status and enable without any added register.
- R9: At a clock edge where a pin's trigger setting differs from its value at the previous edge, no edge detection is reported for that pin.
- R10: After synchronous reset, status and `irq_o` are 0. The pin sample taken during reset serves as the previous sample, so pins that are already high produce no edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | NPORTS*PINS | Synchronised pin levels |
| trig_cfg_i | input | NPORTS*3*PINS | Per-port trigger settings (polarity, edge, dual fields) |
| en_i | input | NPORTS*PINS | Per-pin interrupt enable |
| clr_i | input | NPORTS*PINS | Per-pin write-one clear pulses |
| stat_o | output | NPORTS*PINS | Sticky per-pin status |
| irq_o | output | 1 | Bank interrupt request |

## Verification
A fresh detection and a clear of the same pin can occur in the same cycle. The bench provokes this in two ways. First, it drives a pin transition together with a clear pulse on an edge-sensed pin. Second, it holds the clear pulse high while a level-sensed pin stays at its active level. In both cases status is expected to remain 1, and once the condition is gone a clear alone must drop status to 0. A swept run applies every trigger setting and every pair of consecutive pin values to every pin, and it alternates the enable so that status and request are judged apart.

// File: rtl/gpio_det_pkg.sv
package gpio_det_pkg;

    // Trigger setting of one pin, gathered from the three fields of its port slice.
    typedef struct packed {
        logic dual;      // both edges when edge sensing is on
        logic edge_sel;  // 1: edge sensed, 0: level sensed
        logic pol;       // 1: rising / high, 0: falling / low
    } trig_cfg_t;

    typedef enum logic [1:0] {
        TRIG_LEVEL     = 2'd0,
        TRIG_EDGE_ONE  = 2'd1,
        TRIG_EDGE_BOTH = 2'd2
    } trig_kind_e;

    function automatic trig_kind_e kind_of(trig_cfg_t c);
        if (!c.edge_sel)
            return TRIG_LEVEL;
        else if (c.dual)
            return TRIG_EDGE_BOTH;
        else
            return TRIG_EDGE_ONE;
    endfunction

    // Detection for one pin. cfg_moved blocks any edge report in the cycle
    // the trigger setting changes.
    function automatic logic trig_hit(trig_cfg_t c, logic cur, logic prv, logic cfg_moved);
        logic rise;
        logic fall;
        logic hit;
        rise = cur & ~prv;
        fall = ~cur & prv;
        case (kind_of(c))
            TRIG_LEVEL:     hit = c.pol ? cur : ~cur;
            TRIG_EDGE_ONE:  hit = ~cfg_moved & (c.pol ? rise : fall);
            TRIG_EDGE_BOTH: hit = ~cfg_moved & (rise | fall);
            default:        hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/gpio_det_cell.sv
module gpio_det_cell
    import gpio_det_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_i,
    input  trig_cfg_t cfg_i,
    input  logic      clr_i,
    output logic      stat_o
);

    logic      prv_q;
    trig_cfg_t cfg_q;
    logic      hit;

    always_comb begin
        hit = trig_hit(cfg_i, pin_i, prv_q, cfg_i != cfg_q);
    end

    always_ff @(posedge clk) begin
        prv_q <= pin_i;
        cfg_q <= cfg_i;
        if (rst)
            stat_o <= 1'b0;
        else
            stat_o <= (stat_o & ~clr_i) | hit;  // a fresh hit beats the clear
    end

endmodule

// File: rtl/gpio_det_port.sv
module gpio_det_port
    import gpio_det_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PINS-1:0]   pins_i,
    input  logic [3*PINS-1:0] lvl_i,
    input  logic [PINS-1:0]   en_i,
    input  logic [PINS-1:0]   clr_i,
    output logic [PINS-1:0]   stat_o,
    output logic              req_o
);

    localparam int EDGE_OFS = PINS;
    localparam int DUAL_OFS = 2 * PINS;

    for (genvar n = 0; n < PINS; n++) begin : g_pin
        trig_cfg_t cfg;
        assign cfg.pol      = lvl_i[n];
        assign cfg.edge_sel = lvl_i[EDGE_OFS + n];
        assign cfg.dual     = lvl_i[DUAL_OFS + n];

        gpio_det_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .pin_i  (pins_i[n]),
            .cfg_i  (cfg),
            .clr_i  (clr_i[n]),
            .stat_o (stat_o[n])
        );
    end

    assign req_o = |(stat_o & en_i);

endmodule

// File: rtl/gpio_det_bank.sv
module gpio_det_bank #(
    parameter int NPORTS = 4,
    parameter int PINS   = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NPORTS*PINS-1:0]     pins_i,
    input  logic [NPORTS*3*PINS-1:0]   trig_cfg_i,
    input  logic [NPORTS*PINS-1:0]     en_i,
    input  logic [NPORTS*PINS-1:0]     clr_i,
    output logic [NPORTS*PINS-1:0]     stat_o,
    output logic                       irq_o
);

    localparam int CFG_W = 3 * PINS;

    logic [NPORTS-1:0] port_req;

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        gpio_det_port #(.PINS(PINS)) u_port (
            .clk    (clk),
            .rst    (rst),
            .pins_i (pins_i[p*PINS +: PINS]),
            .lvl_i  (trig_cfg_i[p*CFG_W +: CFG_W]),
            .en_i   (en_i[p*PINS +: PINS]),
            .clr_i  (clr_i[p*PINS +: PINS]),
            .stat_o (stat_o[p*PINS +: PINS]),
            .req_o  (port_req[p])
        );
    end

    assign irq_o = |port_req;

endmodule

// File: rtl/gpio_det_bank_chk.sv
module gpio_det_bank_chk #(
    parameter int NPORTS = 4,
    parameter int PINS   = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic [NPORTS*PINS-1:0]   pins_i,
    input logic [NPORTS*3*PINS-1:0] trig_cfg_i,
    input logic [NPORTS*PINS-1:0]   en_i,
    input logic [NPORTS*PINS-1:0]   clr_i,
    input logic [NPORTS*PINS-1:0]   stat_o,
    input logic                     irq_o
);

    localparam int W = NPORTS * PINS;

    logic [W-1:0] edge_mask;
    logic [W-1:0] active;

    always_comb begin
        for (int i = 0; i < W; i++) begin
            edge_mask[i] = trig_cfg_i[(i / PINS) * 3 * PINS + PINS + (i % PINS)];
            active[i] = !edge_mask[i] &&
                        (trig_cfg_i[(i / PINS) * 3 * PINS + (i % PINS)] == pins_i[i]);
        end
    end

    // R8
    irq_gating_chk: assert property (@(posedge clk) disable iff (rst)
        ((stat_o & en_i) != '0) |-> irq_o);

    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (en_i == '0) |-> !irq_o);

    // R6
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((($past(stat_o) & ~$past(clr_i)) & ~stat_o) == '0));

    // R2
    no_edge_when_still_chk: assert property (@(posedge clk) disable iff (rst)
        ((pins_i == $past(pins_i)) && (trig_cfg_i == $past(trig_cfg_i)))
        |=> ((stat_o & ~$past(stat_o) & $past(edge_mask)) == '0));

    // R5
    level_sets_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (($past(active) & ~stat_o) == '0));

endmodule

bind gpio_det_bank gpio_det_bank_chk #(.NPORTS(NPORTS), .PINS(PINS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pins_i     (pins_i),
    .trig_cfg_i (trig_cfg_i),
    .en_i       (en_i),
    .clr_i      (clr_i),
    .stat_o     (stat_o),
    .irq_o      (irq_o)
);

// File: tb/test_gpio_det_bank.sv
module test_gpio_det_bank;

    localparam int NPORTS = 4;
    localparam int PINS   = 8;
    localparam int W      = NPORTS * PINS;
    localparam int CW     = NPORTS * 3 * PINS;

    logic          clk = 1'b0;
    logic          rst;
    logic [W-1:0]  pins;
    logic [CW-1:0] cfg;
    logic [W-1:0]  en;
    logic [W-1:0]  clr;
    logic [W-1:0]  stat;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    gpio_det_bank #(.NPORTS(NPORTS), .PINS(PINS)) i_gpio_det_bank (
        .clk        (clk),
        .rst        (rst),
        .pins_i     (pins),
        .trig_cfg_i (cfg),
        .en_i       (en),
        .clr_i      (clr),
        .stat_o     (stat),
        .irq_o      (irq)
    );

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // returns {dual, edge, pol}
    function automatic logic [2:0] mode_bits(int m);
        case (m)
            0: return 3'b011;  // rising
            1: return 3'b010;  // falling
            2: return 3'b110;  // both edges, polarity 0
            3: return 3'b001;  // level high
            4: return 3'b000;  // level low
            5: return 3'b111;  // both edges, polarity 1
            6: return 3'b101;  // dual bit with level high: dual ignored
            default: return 3'b011;
        endcase
    endfunction

    task automatic set_mode(int k, int m);
        logic [2:0] b;
        int base;
        b = mode_bits(m);
        base = (k / PINS) * 3 * PINS;
        cfg[base + (k % PINS)]            = b[0];
        cfg[base + PINS + (k % PINS)]     = b[1];
        cfg[base + 2 * PINS + (k % PINS)] = b[2];
    endtask

    // Status expected after one edge with previous sample a and current b.
    function automatic logic exp_hit(int m, logic a, logic b);
        case (m)
            0: return !a && b;
            1: return a && !b;
            2, 5: return a != b;
            3, 6: return a || b;
            4: return !a || !b;
            default: return 1'b0;
        endcase
    endfunction

    // Status expected after a clear with the pin held at b.
    function automatic logic exp_after_clr(int m, logic b);
        case (m)
            3, 6: return b;
            4: return !b;
            default: return 1'b0;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] e;
        int trial;
        rst = 1'b1;
        pins = '1;
        en = '1;
        clr = '0;
        cfg = '0;
        for (int k = 0; k < W; k++) set_mode(k, 0);
        repeat (3) @(negedge clk);
        // R10: reset state
        check(stat == '0, "R10 status at reset", stat, '0);
        check(irq == 1'b0, "R10 irq at reset", W'(irq), '0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        // R10: pins high during reset make no rising edge afterwards
        check(stat == '0, "R10 no edge after reset", stat, '0);
        pins = '0;
        @(negedge clk);
        clr = '1;
        @(negedge clk);
        clr = '0;

        // Sweep: every mode, every (a,b) pair, every pin (R1..R5, R6, R8)
        trial = 0;
        for (int m = 0; m < 7; m++) begin
            for (int k = 0; k < W; k++) begin
                for (int ab = 0; ab < 4; ab++) begin
                    logic a;
                    logic b;
                    logic h;
                    a = ab[1];
                    b = ab[0];
                    en = trial[0] ? '1 : ~(W'(1) << k);
                    for (int j = 0; j < W; j++) set_mode(j, 0);
                    set_mode(k, m);
                    pins = W'(a) << k;
                    clr = '1;
                    @(negedge clk);
                    @(negedge clk);
                    pins = W'(b) << k;
                    clr = '0;
                    @(negedge clk);
                    h = exp_hit(m, a, b);
                    e = W'(h) << k;
                    // R1 R2 R3 R4 R5: detection on the addressed pin only
                    check(stat == e, "R1-map R2 R3 R4 R5 detect", stat, e);
                    // R8: request gated by enable, status independent of it
                    check(irq == (h && en[k]), "R8 irq", W'(irq), W'(h && en[k]));
                    clr = W'(1) << k;
                    @(negedge clk);
                    e = W'(exp_after_clr(m, b)) << k;
                    // R6 R7: clear drops status unless level still active
                    check(stat == e, "R6 R7 clear", stat, e);
                    clr = '0;
                    trial++;
                end
            end
        end

        // R7: edge arrives together with clear on an edge-sensed pin
        en = '1;
        for (int j = 0; j < W; j++) set_mode(j, 0);
        set_mode(13, 2);
        pins = '0;
        clr = '1;
        @(negedge clk);
        @(negedge clk);
        clr = '0;
        pins[13] = 1'b1;
        @(negedge clk);
        check(stat == (W'(1) << 13), "R7 status set before race", stat, W'(1) << 13);
        pins[13] = 1'b0;
        clr[13] = 1'b1;
        @(negedge clk);
        check(stat == (W'(1) << 13), "R7 edge beats clear", stat, W'(1) << 13);
        pins[13] = 1'b0;
        @(negedge clk);
        check(stat == '0, "R7 clear alone afterwards", stat, '0);
        clr = '0;

        // R9: setting change in the same cycle as an edge reports nothing
        set_mode(21, 0);
        pins = '0;
        @(negedge clk);
        @(negedge clk);
        set_mode(21, 2);
        pins[21] = 1'b1;
        @(negedge clk);
        check(stat == '0, "R9 edge suppressed on setting change", stat, '0);
        pins[21] = 1'b0;
        @(negedge clk);
        check(stat == (W'(1) << 21), "R9 edge seen once setting is stable",
              stat, W'(1) << 21);

        // R8: irq follows enable without a register
        en = '0;
        #1;
        check(irq == 1'b0, "R8 irq drops with enable", W'(irq), '0);
        en[21] = 1'b1;
        #1;
        check(irq == 1'b1, "R8 irq rises with enable", W'(irq), W'(1));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule